// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor subsystem between three power conditions: normal running, a light sleep in which only the CPU clock is held, and a deep stop in which the main oscillator and every main-derived clock are switched off. The processor asks for sleep or deep stop with a one-cycle pulse when it executes the matching instruction. Deep stop is guarded by a one-byte unlock register. Only a whole-byte write of the unlock key arms it. A bit-level set or clear aimed at it is reported on a flag and otherwise dropped. Each accepted deep-stop entry wipes the key, so the next entry needs a new unlock write.

Any external interrupt line, or a reset request, ends either low-power mode. Sleep ends on the next clock because nothing was stopped. Leaving deep stop is slower. The oscillator is enabled first, and the system and peripheral clocks stay gated for a power-of-two number of main-clock cycles while it settles. Then the block raises a one-cycle resume strobe, or a one-cycle core reset pulse if a reset request caused the wake-up. While the system is not running, port retention is held so that pins keep their last driven values. The watch-timer and watchdog enables live in the sub-clock domain and stay on in every mode.

Top module: `pwrmode_sequencer`

## Requirements
- R1: When a stop pulse arrives in run mode and the unlock register holds KEY_VALUE (default 0x5A), the block enters deep stop on the next clock. With any other register value, the stop pulse has no effect and the block keeps running.
- R2: A write with the bit-operation qualifier set leaves the unlock register unchanged. It raises bitop_flag for exactly the cycle after the write.
- R3: From the cycle after a deep-stop entry until release, osc_en, sysclk_en and perclk_en are all 0.
- R4: From the first sub-clock edge after reset, wtimer_en and wdog_en are 1 in every mode.
- R5: port_hold is 1 in sleep, deep stop and stabilization. It is 0 while running, including straight after reset.
- R6: A sleep pulse in run mode makes sysclk_en 0 on the next clock, while osc_en and perclk_en stay 1. When any interrupt line is high during sleep, the block returns to run mode on the next clock and raises wake_done for one cycle, with no stabilization wait.
- R7: When any interrupt line is high during deep stop, osc_en becomes 1 on the next clock. sysclk_en and perclk_en stay 0 for exactly 2^STAB_LOG2 cycles. sysclk_en then rises together with a one-cycle wake_done.
- R8: A reset request during deep stop runs the same stabilization wait, then gives a one-cycle core_rst instead of wake_done. A reset request in run or sleep mode gives core_rst on the next clock and leaves the block in run mode. A reset request takes precedence over interrupts.
- R9: The unlock register reads as cleared after each deep-stop entry and after each core reset. A second stop pulse without a new key write keeps the block running.
- R10: When stop and sleep pulses arrive together, the block enters deep stop if the key is valid and sleep otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock; the sequencer and the stabilization count run on it |
| clk_sub | input | 1 | Sub clock, free-running in every mode |
| rst_n | input | 1 | Asynchronous active-low block reset |
| key_wr_en | input | 1 | Write strobe for the unlock register |
| key_wr_bitop | input | 1 | Marks the current write as a bit-level set or clear |
| key_wr_data | input | 8 | Write data for the unlock register |
| stop_exec | input | 1 | One-cycle pulse: stop instruction executed |
| sleep_exec | input | 1 | One-cycle pulse: sleep instruction executed |
| irq_lines | input | N_IRQ | External interrupt lines, active high |
| wake_rst | input | 1 | Reset request from the reset pin, synchronous |
| osc_en | output | 1 | Main oscillator enable |
| sysclk_en | output | 1 | System (CPU) clock enable |
| perclk_en | output | 1 | Peripheral clock enable |
| port_hold | output | 1 | Port output retention |
| wake_done | output | 1 | One-cycle resume strobe after a wake-up by interrupt |
| core_rst | output | 1 | One-cycle internal reset pulse after a reset request |
| bitop_flag | output | 1 | One-cycle flag for a rejected bit-level key write |
| wtimer_en | output | 1 | Watch timer enable (sub-clock domain) |
| wdog_en | output | 1 | Watchdog enable (sub-clock domain) |

## Verification
The bench builds the block with STAB_LOG2 = 4 and N_IRQ = 4. A deep-stop release therefore lasts 16 cycles instead of 2^18. Under this setting the bench can repeat the stop–wake cycle many times and count every gated cycle exactly. It can also exercise reset-driven release and interrupt-driven release one after the other. The default key value is kept, so the random key writes hit both the matching byte and near misses.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_STOP  = 2'd2,
    PM_STAB  = 2'd3
  } pm_state_e;

  // Unlock comparison: the whole byte must equal the reference key.
  function automatic logic key_matches(input logic [7:0] k, input logic [7:0] ref_k);
    return (k == ref_k);
  endfunction

  // Last count value of a 2**log2 window (counter starts at zero).
  function automatic logic count_expired(input logic [31:0] cnt, input int unsigned log2);
    logic [31:0] last;
    last = (32'd1 << log2) - 32'd1;
    return (cnt == last);
  endfunction

endpackage

// File: rtl/pm_key_reg.sv
module pm_key_reg
  import pwrmode_pkg::*;
#(
  parameter logic [7:0] KEY_VALUE = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_bitop,
  input  logic [7:0] wr_data,
  input  logic       clr,
  output logic       key_ok,
  output logic       bitop_flag
);

  logic [7:0] key_q;
  logic       full_wr;
  logic       bit_wr;

  assign full_wr = wr_en && !wr_bitop;
  assign bit_wr  = wr_en && wr_bitop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q      <= 8'h00;
      bitop_flag <= 1'b0;
    end else begin
      bitop_flag <= bit_wr;
      if (clr) begin
        key_q <= 8'h00;
      end else if (full_wr) begin
        key_q <= wr_data;
      end
    end
  end

  assign key_ok = key_matches(key_q, KEY_VALUE);

  // R2: a bit-level write never alters the stored key
  p_bitop_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !clr) |=> $stable(key_q));

  // R9: after a clear the key no longer unlocks
  p_key_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !key_ok);

endmodule

// File: rtl/pm_stab_timer.sv
module pm_stab_timer
  import pwrmode_pkg::*;
#(
  parameter int unsigned STAB_LOG2 = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  logic [STAB_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && count_expired(32'(cnt_q), STAB_LOG2);

  // R7: the window advances by one per cycle and never wraps before done
  p_count_steps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
  import pwrmode_pkg::*;
#(
  parameter int unsigned N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_exec,
  input  logic             sleep_exec,
  input  logic             key_ok,
  input  logic [N_IRQ-1:0] irq,
  input  logic             wake_rst,
  input  logic             stab_done,
  output pm_state_e        state,
  output logic             key_clr,
  output logic             wake_done,
  output logic             core_rst
);

  pm_state_e st_q, st_d;
  logic      rsn_q, rsn_d;     // 1: stabilization was started by a reset request
  logic      wake_evt, rst_evt;
  logic      any_irq;

  assign any_irq = |irq;

  always_comb begin
    st_d     = st_q;
    rsn_d    = rsn_q;
    key_clr  = 1'b0;
    wake_evt = 1'b0;
    rst_evt  = 1'b0;
    unique case (st_q)
      PM_RUN: begin
        if (wake_rst) begin
          rst_evt = 1'b1;
          key_clr = 1'b1;
        end else if (stop_exec && key_ok) begin
          st_d    = PM_STOP;
          rsn_d   = 1'b0;
          key_clr = 1'b1;
        end else if (sleep_exec) begin
          st_d = PM_SLEEP;
        end
      end
      PM_SLEEP: begin
        if (wake_rst) begin
          st_d    = PM_RUN;
          rst_evt = 1'b1;
          key_clr = 1'b1;
        end else if (any_irq) begin
          st_d     = PM_RUN;
          wake_evt = 1'b1;
        end
      end
      PM_STOP: begin
        if (wake_rst) begin
          st_d  = PM_STAB;
          rsn_d = 1'b1;
        end else if (any_irq) begin
          st_d  = PM_STAB;
          rsn_d = 1'b0;
        end
      end
      PM_STAB: begin
        rsn_d = rsn_q | wake_rst;
        if (stab_done) begin
          st_d = PM_RUN;
          if (rsn_d) begin
            rst_evt = 1'b1;
            key_clr = 1'b1;
          end else begin
            wake_evt = 1'b1;
          end
        end
      end
      default: st_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= PM_RUN;
      rsn_q     <= 1'b0;
      wake_done <= 1'b0;
      core_rst  <= 1'b0;
    end else begin
      st_q      <= st_d;
      rsn_q     <= rsn_d;
      wake_done <= wake_evt;
      core_rst  <= rst_evt;
    end
  end

  assign state = st_q;

  // R1: a stop pulse with a valid key enters deep stop
  p_stop_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && stop_exec && key_ok && !wake_rst) |=> (st_q == PM_STOP));

  // R1: without the key the stop pulse cannot reach deep stop
  p_key_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && stop_exec && !key_ok) |=> (st_q != PM_STOP));

  // R6: sleep is left on the next clock with a resume strobe
  p_sleep_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SLEEP && any_irq && !wake_rst) |=> (st_q == PM_RUN && wake_done));

  // R8: resume strobe and core reset never coincide
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_done && core_rst));

endmodule

// File: rtl/pwrmode_sequencer.sv
module pwrmode_sequencer
  import pwrmode_pkg::*;
#(
  parameter logic [7:0]  KEY_VALUE = 8'h5A,
  parameter int unsigned STAB_LOG2 = 18,
  parameter int unsigned N_IRQ     = 4
) (
  input  logic             clk_main,
  input  logic             clk_sub,
  input  logic             rst_n,
  input  logic             key_wr_en,
  input  logic             key_wr_bitop,
  input  logic [7:0]       key_wr_data,
  input  logic             stop_exec,
  input  logic             sleep_exec,
  input  logic [N_IRQ-1:0] irq_lines,
  input  logic             wake_rst,
  output logic             osc_en,
  output logic             sysclk_en,
  output logic             perclk_en,
  output logic             port_hold,
  output logic             wake_done,
  output logic             core_rst,
  output logic             bitop_flag,
  output logic             wtimer_en,
  output logic             wdog_en
);

  pm_state_e st;
  logic      key_ok;
  logic      key_clr;
  logic      stab_run;
  logic      stab_done;
  logic      sleep_active;

  pm_key_reg #(.KEY_VALUE(KEY_VALUE)) u_key (
    .clk        (clk_main),
    .rst_n      (rst_n),
    .wr_en      (key_wr_en),
    .wr_bitop   (key_wr_bitop),
    .wr_data    (key_wr_data),
    .clr        (key_clr),
    .key_ok     (key_ok),
    .bitop_flag (bitop_flag)
  );

  pm_stab_timer #(.STAB_LOG2(STAB_LOG2)) u_stab (
    .clk   (clk_main),
    .rst_n (rst_n),
    .run   (stab_run),
    .done  (stab_done)
  );

  pm_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk        (clk_main),
    .rst_n      (rst_n),
    .stop_exec  (stop_exec),
    .sleep_exec (sleep_exec),
    .key_ok     (key_ok),
    .irq        (irq_lines),
    .wake_rst   (wake_rst),
    .stab_done  (stab_done),
    .state      (st),
    .key_clr    (key_clr),
    .wake_done  (wake_done),
    .core_rst   (core_rst)
  );

  assign stab_run     = (st == PM_STAB);
  assign sleep_active = (st == PM_SLEEP);

  assign osc_en    = (st != PM_STOP);
  assign sysclk_en = (st == PM_RUN);
  assign perclk_en = (st == PM_RUN) || (st == PM_SLEEP);
  assign port_hold = (st != PM_RUN);

  // Sub-clock consumers: enabled on the first sub edge, never touched by mode.
  always_ff @(posedge clk_sub or negedge rst_n) begin
    if (!rst_n) begin
      wtimer_en <= 1'b0;
      wdog_en   <= 1'b0;
    end else begin
      wtimer_en <= 1'b1;
      wdog_en   <= 1'b1;
    end
  end

  // R3: accepted entry switches every main-derived clock off
  p_stop_clocks_off_r3: assert property (@(posedge clk_main) disable iff (!rst_n)
    (sysclk_en && stop_exec && key_ok && !wake_rst) |=> (!osc_en && !sysclk_en && !perclk_en));

  // R7: the system clock only returns after the window or from sleep
  p_gate_until_stab_r7: assert property (@(posedge clk_main) disable iff (!rst_n)
    $rose(sysclk_en) |-> ($past(stab_done) || $past(sleep_active)));

  // R4: once on, sub-clock consumers stay on
  p_always_on_r4: assert property (@(posedge clk_sub) disable iff (!rst_n)
    wtimer_en |=> (wtimer_en && wdog_en));

endmodule

// File: tb/pwrmode_sequencer_tb_top.sv
module pwrmode_sequencer_tb_top;

  localparam int unsigned STAB_LOG2 = 4;
  localparam int unsigned N_IRQ     = 4;
  localparam logic [7:0]  KEY       = 8'h5A;

  logic clk_main = 1'b0;
  logic clk_sub  = 1'b0;
  logic rst_n    = 1'b0;
  logic key_wr_en = 1'b0, key_wr_bitop = 1'b0;
  logic [7:0] key_wr_data = 8'h00;
  logic stop_exec = 1'b0, sleep_exec = 1'b0, wake_rst = 1'b0;
  logic [N_IRQ-1:0] irq_lines = '0;
  logic osc_en, sysclk_en, perclk_en, port_hold, wake_done, core_rst;
  logic bitop_flag, wtimer_en, wdog_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [7:0] key_m = 8'h00;

  always #4 clk_main = ~clk_main;
  always #20 clk_sub = ~clk_sub;

  pwrmode_sequencer #(.KEY_VALUE(KEY), .STAB_LOG2(STAB_LOG2), .N_IRQ(N_IRQ)) dut_i (
    .clk_main, .clk_sub, .rst_n, .key_wr_en, .key_wr_bitop, .key_wr_data,
    .stop_exec, .sleep_exec, .irq_lines, .wake_rst,
    .osc_en, .sysclk_en, .perclk_en, .port_hold, .wake_done, .core_rst,
    .bitop_flag, .wtimer_en, .wdog_en
  );

  function automatic int stab_len();
    return 1 << STAB_LOG2;
  endfunction

  function automatic bit model_enters(input logic [7:0] k);
    return k == KEY;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_main);
    #1;
    stop_exec = 1'b0; sleep_exec = 1'b0; key_wr_en = 1'b0; key_wr_bitop = 1'b0;
    wake_rst = 1'b0; irq_lines = '0;
  endtask

  task automatic write_key(input logic [7:0] v, input bit bitop);
    key_wr_en = 1'b1; key_wr_bitop = bitop; key_wr_data = v;
    tick();
    if (!bitop) key_m = v;
    chk(bitop_flag == bitop, "R2 bitop_flag", int'(bitop_flag), int'(bitop));
  endtask

  task automatic wait_run(output int n);
    n = 0;
    while (!sysclk_en && n < 1000) begin
      chk(osc_en && !perclk_en && port_hold, "R7 gated window", int'({osc_en, perclk_en, port_hold}), 5);
      tick();
      n++;
    end
  endtask

  task automatic enter_stop();
    stop_exec = 1'b1;
    tick();
    chk({osc_en, sysclk_en, perclk_en} == 3'b000, "R3 clocks off", int'({osc_en, sysclk_en, perclk_en}), 0);
    chk(port_hold, "R5 hold in stop", int'(port_hold), 1);
    key_m = 8'h00;
  endtask

  task automatic wake_stop_irq(input logic [N_IRQ-1:0] lines);
    int n;
    irq_lines = lines;
    tick();
    chk(osc_en && !sysclk_en, "R7 osc first", int'({osc_en, sysclk_en}), 2);
    wait_run(n);
    chk(n == stab_len(), "R7 window length", n, stab_len());
    chk(wake_done && !core_rst, "R7 wake_done", int'({wake_done, core_rst}), 2);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd2024);
    repeat (4) @(posedge clk_main);
    #1 rst_n = 1'b1;
    #1;
    chk({osc_en, sysclk_en, perclk_en} == 3'b111, "R5 reset clocks", int'({osc_en, sysclk_en, perclk_en}), 7);
    chk(!port_hold && !wake_done && !core_rst, "R5 reset hold", int'({port_hold, wake_done, core_rst}), 0);
    repeat (12) tick();
    chk(wtimer_en && wdog_en, "R4 sub enables", int'({wtimer_en, wdog_en}), 3);

    // R1: stop with no key
    stop_exec = 1'b1; tick();
    chk(sysclk_en && osc_en, "R1 no key keeps run", int'(sysclk_en), 1);

    // R2: bit-level write of the key is rejected
    write_key(KEY, 1'b1);
    stop_exec = 1'b1; tick();
    chk(sysclk_en, "R2 bitop does not arm", int'(sysclk_en), 1);
    tick();
    chk(!bitop_flag, "R2 flag one cycle", int'(bitop_flag), 0);

    // R1/R3/R7: proper unlock, stop, wake by interrupt
    write_key(KEY, 1'b0);
    enter_stop();
    repeat (5) tick();
    chk(!osc_en && !sysclk_en, "R3 stays stopped", int'({osc_en, sysclk_en}), 0);
    chk(wtimer_en && wdog_en, "R4 on in stop", int'({wtimer_en, wdog_en}), 3);
    wake_stop_irq(4'b0100);
    tick();
    chk(!wake_done && !port_hold, "R7 strobe one cycle", int'({wake_done, port_hold}), 0);

    // R9: key consumed by the entry
    stop_exec = 1'b1; tick();
    chk(sysclk_en, "R9 second stop needs key", int'(sysclk_en), 1);

    // R6: sleep and fast release
    sleep_exec = 1'b1; tick();
    chk({osc_en, sysclk_en, perclk_en, port_hold} == 4'b1011, "R6 sleep clocks",
        int'({osc_en, sysclk_en, perclk_en, port_hold}), 11);
    irq_lines = 4'b0001; tick();
    chk(sysclk_en && wake_done, "R6 sleep wake", int'({sysclk_en, wake_done}), 3);

    // R10: both pulses, key invalid -> sleep
    write_key(8'h5B, 1'b0);
    stop_exec = 1'b1; sleep_exec = 1'b1; tick();
    chk(osc_en && perclk_en && !sysclk_en, "R10 sleep wins", int'({osc_en, perclk_en, sysclk_en}), 6);
    irq_lines = 4'b1000; tick();

    // R10: both pulses, key valid -> stop; then R8 reset wake
    write_key(KEY, 1'b0);
    sleep_exec = 1'b1;
    enter_stop();
    wake_rst = 1'b1; irq_lines = 4'b0010; tick();
    wait_run(n);
    chk(n == stab_len(), "R8 reset window", n, stab_len());
    chk(core_rst && !wake_done, "R8 core_rst not wake", int'({core_rst, wake_done}), 2);

    // R8: reset in run and in sleep
    write_key(KEY, 1'b0);
    wake_rst = 1'b1; tick();
    chk(core_rst && sysclk_en, "R8 run reset", int'({core_rst, sysclk_en}), 3);
    key_m = 8'h00;
    stop_exec = 1'b1; tick();
    chk(sysclk_en, "R9 reset clears key", int'(sysclk_en), 1);
    sleep_exec = 1'b1; tick();
    wake_rst = 1'b1; tick();
    chk(core_rst && sysclk_en && !wake_done, "R8 sleep reset", int'({core_rst, sysclk_en, wake_done}), 6);

    // Random mix of key writes and stop attempts
    for (int i = 0; i < 80; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 4) begin
        logic [7:0] v = ($urandom_range(0, 2) == 0) ? KEY : 8'($urandom());
        write_key(v, 1'b0);
      end else if (r < 6) begin
        write_key(8'($urandom()), 1'b1);
      end else begin
        bit exp_stop = model_enters(key_m);
        stop_exec = 1'b1; tick();
        chk(sysclk_en == !exp_stop, "R1 random stop", int'(sysclk_en), int'(!exp_stop));
        if (!sysclk_en) begin
          key_m = 8'h00;
          wake_stop_irq(4'($urandom_range(1, 15)));
        end
      end
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule